// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt lines from peripherals and from software and routes each one to the CPU interfaces of a small multiprocessor. Software configures it through a 32-bit register bus. For every interrupt it keeps an enable bit, a pending state, a priority, a trigger mode and a CPU target field. On every cycle it offers each CPU the most urgent interrupt that is pending, enabled and aimed at that CPU. The offer is registered, so it follows a state change by one clock.

Interrupt IDs 0 to 15 are software-generated. IDs 16 to 31 are private to each CPU and come from a separate input line per CPU. IDs 32 and above are shared peripheral inputs. For IDs 0 to 31 the enable and pending state is held once per CPU. The bus carries the number of the accessing CPU, and that number selects the copy that is read or written. Each shared interrupt has a 16-bit target field, and two of these fields are packed into each 32-bit word. The software-trigger register carries a 16-bit CPU list that starts at bit 8.

Top module: `intdist_top`

## Requirements
- R1: Bit 0 of the control word at byte offset 0x000 gates all forwarding. While it is 0, every `cpu_irq` bit is 0 from the following clock onward. Its reset value is 0.
- R2: The enable state is written through a set bank at 0x100 and a clear bank at 0x180. Interrupt n is bit n%32 of word n/32. A 1 bit sets or clears that enable, and a 0 bit changes nothing. Both banks read back the current enables. After reset every enable is 0.
- R3: The target bank starts at 0x800, and the target of interrupt n is at byte offset (n*2)&~3 within it. Even IDs use bits 15:0 and odd IDs use bits 31:16. Bit c of a field selects CPU c. Field bits above the CPU count read as 0.
- R4: A read of a target word for IDs 0 to 31 returns the one-hot mask of the reading CPU in both halves. Writes to those words are ignored.
- R5: For IDs 0 to 31, the enable and pending bits are separate for each CPU. Only the copy of the CPU on `bus_cpu` is read or written.
- R6: Writing (list<<8)|id to 0x008 makes software interrupt id pending on each CPU c whose list bit 8+c is set. The id is taken from bits 3:0. List bits for CPUs that do not exist have no effect. The register reads as 0.
- R7: The type word at 0x004 reads NUM_SRC/32-1 in bits 4:0 and 0 in all other bits.
- R8: The configuration bank at 0xC00 selects the trigger of interrupt n with bit 2*(n%16)+1 of word n/16. A 1 selects rising edge and a 0 selects level high. IDs 0 to 15 always read as edge, and writes to them are ignored.
- R9: A level interrupt is pending while its line is high. A rising edge on an edge interrupt latches it pending, and it stays pending until software clears it. The pending bank is read or set at 0x200 and cleared at 0x280, with the same bit layout as R2.
- R10: For each CPU the block offers the interrupt with the lowest priority value among those that are pending, enabled and, for shared IDs, targeted at that CPU. When priorities are equal, the lower ID wins. The offer appears one clock after the state it reflects. Priorities are 4-bit fields at 0x400, with interrupt n in bits 4*(n%8)+3:4*(n%8) of word n/8.
- R11: Offsets outside the implemented registers read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | CPU_W | Number of the CPU making the bus access |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_in | input | NUM_SRC-32 | Shared interrupt lines, bit s is ID 32+s |
| ppi_in | input | NUM_CPU*16 | Private lines, bit c*16+k is ID 16+k of CPU c |
| cpu_irq | output | NUM_CPU | An interrupt is offered to CPU c |
| cpu_id | output | NUM_CPU*ID_W | Offered ID, field c |
| cpu_prio | output | NUM_CPU*PRIO_W | Priority of the offered ID, field c |

## Verification
A wrong enable, pending, target or priority bit shows up on the ports in two ways. A register read of the affected word returns a wrong value in the same cycle. The affected CPU's offer on `cpu_irq` and `cpu_id` goes wrong one clock after the state changes. An edge latch that fails to hold shows up as an offer that vanishes once the line falls. A broken per-CPU copy shows up as a second CPU seeing the first CPU's bits, or as an offer reaching the wrong CPU. Each scenario reads back the registers and then waits for the registered offer before sampling it.

// File: rtl/intdist_pkg.sv
package intdist_pkg;

   localparam int unsigned ADDR_W = 12;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_CTRL,
      RG_TYPE,
      RG_SWTRIG,
      RG_ENSET,
      RG_ENCLR,
      RG_PSET,
      RG_PCLR,
      RG_PRIO,
      RG_TGT,
      RG_CFG
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [7:0] widx;
   } reg_sel_t;

   // Map a byte address to a register kind and a word index within its bank.
   function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int unsigned nsrc);
      reg_sel_t r;
      r.kind = RG_NONE;
      r.widx = '0;
      case (a[11:8])
         4'h0: begin
            case (a[7:0])
               8'h00:   r.kind = RG_CTRL;
               8'h04:   r.kind = RG_TYPE;
               8'h08:   r.kind = RG_SWTRIG;
               default: r.kind = RG_NONE;
            endcase
         end
         4'h1, 4'h2: begin
            if (32'(a[6:2]) < nsrc / 32) begin
               r.widx = 8'(a[6:2]);
               if (a[9]) r.kind = a[7] ? RG_PCLR : RG_PSET;
               else      r.kind = a[7] ? RG_ENCLR : RG_ENSET;
            end
         end
         4'h4: begin
            if (32'(a[7:2]) < nsrc / 8) begin
               r.widx = 8'(a[7:2]);
               r.kind = RG_PRIO;
            end
         end
         4'h8, 4'h9, 4'hA, 4'hB: begin
            if (32'(a[9:2]) < nsrc / 2) begin
               r.widx = a[9:2];
               r.kind = RG_TGT;
            end
         end
         4'hC: begin
            if (32'(a[7:2]) < nsrc / 16) begin
               r.widx = 8'(a[7:2]);
               r.kind = RG_CFG;
            end
         end
         default: r.kind = RG_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/intdist_pend_cell.sv
module intdist_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic edge_i,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);

   logic line_q;
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         line_q <= line_i;
         if (set_i || (edge_i && line_i && !line_q)) begin
            latch_q <= 1'b1;
         end else if (clr_i) begin
            latch_q <= 1'b0;
         end
      end
   end

   // A level source is pending for as long as its line is high.
   assign pend_o = latch_q | (!edge_i & line_i);

endmodule

// File: rtl/intdist_arbiter.sv
module intdist_arbiter #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ID_W    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             elig_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [ID_W-1:0]                id_o,
   output logic [PRIO_W-1:0]              prio_o
);

   logic              found;
   logic [ID_W-1:0]   best_id;
   logic [PRIO_W-1:0] best_p;

   // Scan from the top ID down; "<=" lets a lower ID win a tie.
   always_comb begin
      found   = 1'b0;
      best_id = '0;
      best_p  = '1;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig_i[i] && (prio_i[i] <= best_p)) begin
            found   = 1'b1;
            best_id = ID_W'(i);
            best_p  = prio_i[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         id_o    <= '0;
         prio_o  <= '0;
      end else begin
         valid_o <= found;
         id_o    <= found ? best_id : '0;
         prio_o  <= found ? best_p : '0;
      end
   end

endmodule

// File: rtl/intdist_top.sv
module intdist_top
   import intdist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned PRIO_W  = 4,
   localparam int unsigned NUM_SH = NUM_SRC - 32,
   localparam int unsigned ID_W   = $clog2(NUM_SRC),
   localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CPU_W-1:0]           bus_cpu,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_SH-1:0]          spi_in,
   input  logic [NUM_CPU*16-1:0]      ppi_in,
   output logic [NUM_CPU-1:0]         cpu_irq,
   output logic [NUM_CPU*ID_W-1:0]    cpu_id,
   output logic [NUM_CPU*PRIO_W-1:0]  cpu_prio
);

   // ---------------- elaboration checks ----------------
   if ((NUM_SRC % 32) != 0 || NUM_SRC < 64 || NUM_SRC > 480) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 between 64 and 480");
   end
   if (NUM_CPU < 2 || NUM_CPU > 16) begin : g_bad_cpu
      $error("NUM_CPU must be between 2 and 16");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("PRIO_W must be between 1 and 4");
   end

   // ---------------- state ----------------
   reg_sel_t                             sel;
   logic                                 ctrl_en;
   logic [NUM_CPU-1:0][31:0]             bk_en;
   logic [NUM_CPU-1:0][31:0]             bk_pend;
   logic [NUM_SH-1:0]                    sh_en;
   logic [NUM_SH-1:0]                    sh_pend;
   logic [NUM_SRC-1:0][PRIO_W-1:0]       prio_q;
   logic [NUM_SH-1:0][NUM_CPU-1:0]       tgt_q;
   logic [NUM_SRC-1:16]                  edge_q;
   logic [NUM_SRC-1:0]                   edge_mode;
   logic [NUM_CPU-1:0][NUM_SRC-1:0]      elig;

   // ---------------- write strobes ----------------
   logic [NUM_SRC-1:0] wbit;
   logic [NUM_SRC-1:0] m_enset, m_enclr, m_pset, m_pclr;
   logic [15:0]        sgi_hit;
   logic [NUM_CPU-1:0] cpu_hit;

   assign sel       = decode_addr(bus_addr, NUM_SRC);
   assign edge_mode = {edge_q, 16'hFFFF};

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         wbit[i]    = bus_wr && (sel.widx == 8'(i / 32)) && bus_wdata[i % 32];
         m_enset[i] = wbit[i] && (sel.kind == RG_ENSET);
         m_enclr[i] = wbit[i] && (sel.kind == RG_ENCLR);
         m_pset[i]  = wbit[i] && (sel.kind == RG_PSET);
         m_pclr[i]  = wbit[i] && (sel.kind == RG_PCLR);
      end
      for (int i = 0; i < 16; i++) begin
         sgi_hit[i] = bus_wr && (sel.kind == RG_SWTRIG) && (bus_wdata[3:0] == 4'(i));
      end
      for (int c = 0; c < NUM_CPU; c++) begin
         cpu_hit[c] = (bus_cpu == CPU_W'(c));
      end
   end

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         bk_en   <= '0;
         sh_en   <= '0;
         prio_q  <= '0;
         tgt_q   <= '0;
         edge_q  <= '0;
      end else begin
         if (bus_wr && sel.kind == RG_CTRL) begin
            ctrl_en <= bus_wdata[0];
         end
         for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < 32; i++) begin
               if (cpu_hit[c]) begin
                  if (m_enset[i])      bk_en[c][i] <= 1'b1;
                  else if (m_enclr[i]) bk_en[c][i] <= 1'b0;
               end
            end
         end
         for (int s = 0; s < NUM_SH; s++) begin
            if (m_enset[32+s])      sh_en[s] <= 1'b1;
            else if (m_enclr[32+s]) sh_en[s] <= 1'b0;
            if (bus_wr && sel.kind == RG_TGT && sel.widx == 8'((32 + s) / 2)) begin
               tgt_q[s] <= bus_wdata[16*(s%2) +: NUM_CPU];
            end
         end
         for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_wr && sel.kind == RG_PRIO && sel.widx == 8'(i / 8)) begin
               prio_q[i] <= bus_wdata[4*(i%8) +: PRIO_W];
            end
         end
         for (int i = 16; i < NUM_SRC; i++) begin
            if (bus_wr && sel.kind == RG_CFG && sel.widx == 8'(i / 16)) begin
               edge_q[i] <= bus_wdata[2*(i%16)+1];
            end
         end
      end
   end

   // ---------------- pending state ----------------
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      for (genvar i = 0; i < 32; i++) begin : g_bank
         logic line_w, set_w, clr_w;
         if (i < 16) begin : g_sgi
            assign line_w = 1'b0;
            assign set_w  = (m_pset[i] & cpu_hit[c]) | (sgi_hit[i] & bus_wdata[8+c]);
         end else begin : g_ppi
            assign line_w = ppi_in[c*16 + i - 16];
            assign set_w  = m_pset[i] & cpu_hit[c];
         end
         assign clr_w = m_pclr[i] & cpu_hit[c];
         intdist_pend_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_w),
            .edge_i (edge_mode[i]),
            .set_i  (set_w),
            .clr_i  (clr_w),
            .pend_o (bk_pend[c][i])
         );
      end
   end

   for (genvar s = 0; s < NUM_SH; s++) begin : g_sh
      intdist_pend_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (spi_in[s]),
         .edge_i (edge_mode[32+s]),
         .set_i  (m_pset[32+s]),
         .clr_i  (m_pclr[32+s]),
         .pend_o (sh_pend[s])
      );
   end

   // ---------------- eligibility and selection ----------------
   always_comb begin
      for (int c = 0; c < NUM_CPU; c++) begin
         for (int i = 0; i < 32; i++) begin
            elig[c][i] = ctrl_en & bk_en[c][i] & bk_pend[c][i];
         end
         for (int s = 0; s < NUM_SH; s++) begin
            elig[c][32+s] = ctrl_en & sh_en[s] & sh_pend[s] & tgt_q[s][c];
         end
      end
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_arb
      intdist_arbiter #(
         .NUM_SRC (NUM_SRC),
         .PRIO_W  (PRIO_W),
         .ID_W    (ID_W)
      ) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .elig_i  (elig[c]),
         .prio_i  (prio_q),
         .valid_o (cpu_irq[c]),
         .id_o    (cpu_id[c*ID_W +: ID_W]),
         .prio_o  (cpu_prio[c*PRIO_W +: PRIO_W])
      );
   end

   // ---------------- read mux ----------------
   logic [NUM_SRC-1:0] en_view, pend_view;
   logic [15:0]        self_mask;

   assign self_mask = 16'(1) << bus_cpu;

   always_comb begin
      en_view   = '0;
      pend_view = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (cpu_hit[c]) begin
            en_view[31:0]   = bk_en[c];
            pend_view[31:0] = bk_pend[c];
         end
      end
      en_view[NUM_SRC-1:32]   = sh_en;
      pend_view[NUM_SRC-1:32] = sh_pend;
   end

   always_comb begin
      bus_rdata = '0;
      case (sel.kind)
         RG_CTRL: bus_rdata[0] = ctrl_en;
         RG_TYPE: bus_rdata[4:0] = 5'(NUM_SRC / 32 - 1);
         RG_ENSET, RG_ENCLR: begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (sel.widx == 8'(i / 32)) bus_rdata[i%32] = en_view[i];
            end
         end
         RG_PSET, RG_PCLR: begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (sel.widx == 8'(i / 32)) bus_rdata[i%32] = pend_view[i];
            end
         end
         RG_PRIO: begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (sel.widx == 8'(i / 8)) bus_rdata[4*(i%8) +: PRIO_W] = prio_q[i];
            end
         end
         RG_TGT: begin
            for (int i = 0; i < 32; i++) begin
               if (sel.widx == 8'(i / 2)) bus_rdata[16*(i%2) +: 16] = self_mask;
            end
            for (int s = 0; s < NUM_SH; s++) begin
               if (sel.widx == 8'((32 + s) / 2)) bus_rdata[16*(s%2) +: NUM_CPU] = tgt_q[s];
            end
         end
         RG_CFG: begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (sel.widx == 8'(i / 16)) bus_rdata[2*(i%16)+1] = edge_mode[i];
            end
         end
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/intdist_chk.sv
module intdist_chk
   import intdist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned ID_W    = 6,
   parameter int unsigned CPU_W   = 2,
   localparam int unsigned NUM_SH = NUM_SRC - 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input reg_kind_e                     kind,
   input logic [7:0]                    widx,
   input logic                          bus_wr,
   input logic [CPU_W-1:0]              bus_cpu,
   input logic [31:0]                   bus_wdata,
   input logic [31:0]                   bus_rdata,
   input logic                          ctrl_en,
   input logic [NUM_CPU-1:0]            cpu_irq,
   input logic [NUM_CPU*ID_W-1:0]       cpu_id,
   input logic [NUM_CPU-1:0][NUM_SRC-1:0] elig,
   input logic [NUM_CPU-1:0][31:0]      bk_en,
   input logic [NUM_CPU-1:0][31:0]      bk_pend,
   input logic [NUM_SH-1:0]             sh_en
);

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq != '0) |-> $past(ctrl_en));

   assert_zero_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (kind == RG_ENSET || kind == RG_ENCLR) && bus_wdata == '0)
      |=> ($stable(bk_en) && $stable(sh_en)));

   assert_private_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == RG_TGT && widx < 8'd16)
      |-> (bus_rdata == {2{16'(1) << bus_cpu}}));

   assert_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == RG_TYPE) |-> (bus_rdata == 32'(NUM_SRC / 32 - 1)));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      assert_swtrig_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && kind == RG_SWTRIG && bus_wdata[8+c])
         |=> bk_pend[c][$past(bus_wdata[3:0])]);

      assert_pick_eligible_R10: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq[c] |->
         ((($past(elig[c]) >> cpu_id[c*ID_W +: ID_W]) & NUM_SRC'(1)) != '0));

      assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !cpu_irq[c] |-> ($past(elig[c]) == '0));
   end

endmodule

bind intdist_top intdist_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_CPU (NUM_CPU),
   .ID_W    (ID_W),
   .CPU_W   (CPU_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .kind      (sel.kind),
   .widx      (sel.widx),
   .bus_wr    (bus_wr),
   .bus_cpu   (bus_cpu),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ctrl_en   (ctrl_en),
   .cpu_irq   (cpu_irq),
   .cpu_id    (cpu_id),
   .elig      (elig),
   .bk_en     (bk_en),
   .bk_pend   (bk_pend),
   .sh_en     (sh_en)
);

// File: tb/test_intdist_top.sv
`timescale 1ns/1ps
module test_intdist_top;

   localparam int NS = 64;
   localparam int NC = 4;
   localparam int IW = 6;
   localparam int PW = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       bus_cpu = '0;
   logic [11:0]      bus_addr = '0;
   logic             bus_wr = 1'b0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NS-33:0]   spi_in = '0;
   logic [NC*16-1:0] ppi_in = '0;
   logic [NC-1:0]    cpu_irq;
   logic [NC*IW-1:0] cpu_id;
   logic [NC*PW-1:0] cpu_prio;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   intdist_top #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(PW)) i_intdist_top (
      .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_in(spi_in), .ppi_in(ppi_in), .cpu_irq(cpu_irq),
      .cpu_id(cpu_id), .cpu_prio(cpu_prio)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cpu = 2'(cpu); bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] idof(input int c);
      return 32'(cpu_id[c*IW +: IW]);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(0, 12'h000, d);  check("R1 ctrl reset", d, 0);
      check("R1 irq reset", 32'(cpu_irq), 0);
      rd(0, 12'h104, d);  check("R2 enable reset", d, 0);
      rd(0, 12'h004, d);  check("R7 type", d, 32'd1);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(0, 12'h104, 32'h5);
      rd(0, 12'h104, d);  check("R2 set", d, 32'h5);
      wr(0, 12'h184, 32'h0);
      rd(0, 12'h104, d);  check("R2 zero clear no effect", d, 32'h5);
      wr(0, 12'h104, 32'h0);
      rd(0, 12'h184, d);  check("R2 zero set no effect", d, 32'h5);
      wr(0, 12'h184, 32'h1);
      rd(0, 12'h184, d);  check("R2 clear", d, 32'h4);
      wr(0, 12'h184, 32'h4);
      wr(1, 12'h100, 32'h0001_0000);
      rd(0, 12'h100, d);  check("R5 other cpu copy", d, 0);
      rd(1, 12'h100, d);  check("R5 own cpu copy", d, 32'h0001_0000);
      wr(1, 12'h180, 32'h0001_0000);
   endtask

   task automatic t_target();
      logic [31:0] d;
      wr(0, 12'h840, 32'h000A_0005);
      rd(0, 12'h840, d);  check("R3 packing", d, 32'h000A_0005);
      wr(0, 12'h844, 32'hFFFF_FFFF);
      rd(0, 12'h844, d);  check("R3 width", d, 32'h000F_000F);
      rd(2, 12'h800, d);  check("R4 cpu2 mask", d, 32'h0004_0004);
      wr(0, 12'h83C, 32'h0);
      rd(0, 12'h83C, d);  check("R4 write ignored", d, 32'h0001_0001);
   endtask

   task automatic t_config();
      logic [31:0] d;
      rd(0, 12'hC00, d);  check("R8 sgi edge", d, 32'hAAAA_AAAA);
      wr(0, 12'hC00, 32'h0);
      rd(0, 12'hC00, d);  check("R8 sgi fixed", d, 32'hAAAA_AAAA);
      wr(0, 12'hC04, 32'h2);
      rd(0, 12'hC04, d);  check("R8 id16 edge", d, 32'h2);
      wr(0, 12'hC04, 32'h0);
   endtask

   task automatic t_unimpl();
      logic [31:0] d;
      wr(0, 12'h00C, 32'hFFFF_FFFF);
      rd(0, 12'h00C, d);  check("R11 hole reads 0", d, 0);
      rd(0, 12'h000, d);  check("R11 ctrl untouched", d, 0);
      wr(0, 12'h108, 32'hFFFF_FFFF);
      rd(0, 12'h108, d);  check("R11 beyond bank", d, 0);
      rd(0, 12'h104, d);  check("R11 bank untouched", d, 0);
      rd(0, 12'h008, d);  check("R6 trigger reads 0", d, 0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(0, 12'h000, 32'h1);
      wr(0, 12'h104, 32'h100);
      wr(0, 12'h414, 32'h3);
      spi_in[8] = 1'b1;
      settle();
      check("R10 untargeted", 32'(cpu_irq), 0);
      wr(0, 12'h850, 32'h2);
      settle();
      check("R10 routed", 32'(cpu_irq), 32'b0010);
      check("R10 id", idof(1), 40);
      check("R10 prio", 32'(cpu_prio[1*PW +: PW]), 3);
      rd(0, 12'h204, d);  check("R9 level pending", d, 32'h100);
      wr(0, 12'h000, 32'h0);
      settle();
      check("R1 gated", 32'(cpu_irq), 0);
      wr(0, 12'h000, 32'h1);
      settle();
      check("R1 regated", 32'(cpu_irq), 32'b0010);
      spi_in[8] = 1'b0;
      settle();
      check("R9 level drop", 32'(cpu_irq), 0);
      rd(0, 12'h204, d);  check("R9 level pending clear", d, 0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(0, 12'hC08, 32'h0008_0000);
      rd(0, 12'hC08, d);  check("R8 id41 edge", d, 32'h0008_0000);
      wr(0, 12'h104, 32'h200);
      wr(0, 12'h850, 32'h0002_0002);
      wr(0, 12'h414, 32'h13);
      @(negedge clk); spi_in[9] = 1'b1;
      @(negedge clk); spi_in[9] = 1'b0;
      settle();
      check("R9 edge held", 32'(cpu_irq), 32'b0010);
      check("R9 edge id", idof(1), 41);
      rd(0, 12'h204, d);  check("R9 edge pending", d, 32'h200);
      wr(0, 12'h284, 32'h200);
      settle();
      check("R9 edge cleared", 32'(cpu_irq), 0);
   endtask

   task automatic t_prio();
      wr(0, 12'h204, 32'h300);
      settle();
      check("R10 lower value wins", idof(1), 41);
      wr(0, 12'h414, 32'h33);
      settle();
      check("R10 tie lower id", idof(1), 40);
      wr(0, 12'h414, 32'h03);
      settle();
      check("R10 zero prio wins", idof(1), 41);
      check("R10 zero prio value", 32'(cpu_prio[1*PW +: PW]), 0);
      wr(0, 12'h284, 32'h300);
      settle();
      check("R10 none pending", 32'(cpu_irq), 0);
   endtask

   task automatic t_sgi();
      logic [31:0] d;
      wr(0, 12'h100, 32'h20);
      wr(3, 12'h100, 32'h20);
      wr(0, 12'h008, 32'h0000_1905);
      settle();
      check("R6 listed cpus", 32'(cpu_irq), 32'b1001);
      check("R6 id cpu0", idof(0), 5);
      check("R6 id cpu3", idof(3), 5);
      rd(1, 12'h200, d);  check("R6 unlisted cpu", d, 0);
      rd(3, 12'h200, d);  check("R5 cpu3 pending", d, 32'h20);
      wr(0, 12'h280, 32'h20);
      settle();
      check("R5 clear own copy", 32'(cpu_irq), 32'b1000);
      wr(3, 12'h280, 32'h20);
      settle();
      check("R5 all clear", 32'(cpu_irq), 0);
   endtask

   task automatic t_ppi();
      wr(2, 12'h100, 32'h0010_0000);
      ppi_in[2*16 + 4] = 1'b1;
      settle();
      check("R5 private line", 32'(cpu_irq), 32'b0100);
      check("R5 private id", idof(2), 20);
      ppi_in[2*16 + 4] = 1'b0;
      settle();
      check("R9 private drop", 32'(cpu_irq), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_target();
      t_config();
      t_unimpl();
      t_level();
      t_edge();
      t_prio();
      t_sgi();
      t_ppi();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule